// File: doc/BRIEF.md
# Double-Talk Detector

This block watches an echo canceller for moments when the near-end talker is active at the same time as the far-end signal. During those moments the residual error no longer reflects only the echo path, so the adaptation engine must stop updating its coefficients. The detector keeps the saturated magnitudes of the most recent far-end samples. On every sample strobe it takes the largest of them, scales that peak by a programmable fraction and compares the scaled peak with the magnitude of the error sample. When the error reaches the scaled peak, the block raises a freeze request.

The decision is registered at the clock edge that takes in the strobed sample pair, so the adaptation engine sees the freeze request on the next clock. The request then holds for a programmable number of further samples after the last detection. This hangover stops the freeze from toggling on and off while a near-end talker pauses briefly between words. A second output reports the raw decision for the latest sample, without the hangover.

Top module: `dtalk_detect`

## Requirements
- R1: While reset is asserted and after its release, until the first strobe, `freeze` and `dt_flag` are 0 and every stored far-end magnitude is 0.
- R2: Samples are two's-complement. A magnitude is the absolute value saturated to 2^(DW-1)-1, so the most negative code -2^(DW-1) has the same magnitude as the largest positive code.
- R3: The peak for a strobe is the largest magnitude among that strobe's far-end sample and the far-end samples of the WIN-1 strobes before it. A sample from WIN or more strobes earlier has no influence.
- R4: A strobe is a detection when |err|·2^FW ≥ thr_frac·peak, with thr_frac read as an unsigned fraction thr_frac/2^FW. For FW=8, a value of 128 means one half.
- R5: A strobe whose peak is 0 is never a detection, whatever the error.
- R6: `dt_flag` and `freeze` change only at the clock edge that samples `smp_vld`=1, and they carry that strobe's result from the next clock onward. `dt_flag` equals that strobe's detection result.
- R7: After a detecting strobe, `freeze` is 1. It remains 1 through the next `hang_len` non-detecting strobes and falls to 0 at the following non-detecting strobe. `hang_len` is sampled at the detecting strobe.
- R8: A detection during the hangover reloads the count, so a new hangover of `hang_len` non-detecting strobes starts from that detection.
- R9: Clocks with `smp_vld`=0 change neither the outputs nor the stored far-end window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Strobe: far_smp and err_smp carry a new sample pair |
| far_smp | input | DW | Far-end sample, two's-complement |
| err_smp | input | DW | Error (near-end residual) sample, two's-complement |
| thr_frac | input | FW | Threshold fraction, value thr_frac/2^FW |
| hang_len | input | HW | Number of further non-detecting strobes that keep the freeze |
| freeze | output | 1 | Request to hold coefficient adaptation |
| dt_flag | output | 1 | Detection result of the most recent strobe |

## Verification
The hardest case to reach from the ports is the edge of the window. A large far-end sample must produce detections for exactly WIN strobes, counting its own, and must stop producing them on the next strobe. Strobe-free clocks mixed into that run must not age the window. Random traffic almost never lines up this way. The bench therefore injects one loud far-end sample and follows it with silent far-end samples whose error sits exactly on the threshold. It places idle clocks in the middle of the run and checks both the last detecting strobe and the first non-detecting one. Further directed cases cover the exact equality point of the comparison, the most negative codes, a zero peak, and reloading the hangover. Long random runs then vary the threshold, the hangover length and the signal amplitudes.

// File: rtl/sat_mag.sv
module sat_mag #(
  parameter int DW = 16,
  localparam int MW = DW - 1
) (
  input  logic [DW-1:0] smp,
  output logic [MW-1:0] mag
);
  function automatic logic [MW-1:0] sat_abs(input logic [DW-1:0] v);
    logic [DW-1:0] neg;
    neg = ~v + 1'b1;
    if (v == {1'b1, {(DW-1){1'b0}}}) return {MW{1'b1}};
    else if (v[DW-1])                return neg[MW-1:0];
    else                             return v[MW-1:0];
  endfunction

  assign mag = sat_abs(smp);
endmodule

// File: rtl/mag_window.sv
module mag_window #(
  parameter int DW  = 16,
  parameter int WIN = 32,
  localparam int MW    = DW - 1,
  localparam int DEPTH = WIN - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] far_smp,
  output logic [MW-1:0] cur_mag,
  output logic [MW-1:0] peak
);
  logic [MW-1:0] hist [DEPTH];

  sat_mag #(.DW(DW)) u_far_mag (.smp(far_smp), .mag(cur_mag));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (smp_vld) begin
      hist[0] <= cur_mag;
      for (int i = 1; i < DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    peak = cur_mag;
    for (int i = 0; i < DEPTH; i++)
      if (hist[i] > peak) peak = hist[i];
  end

  // R3
  recent_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> peak >= $past(cur_mag));

  // R9
  idle_window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(hist[0]) && $stable(hist[DEPTH-1]));
endmodule

// File: rtl/dt_compare.sv
module dt_compare #(
  parameter int MW = 15,
  parameter int FW = 8,
  localparam int PW = MW + FW
) (
  input  logic [MW-1:0] err_mag,
  input  logic [MW-1:0] peak,
  input  logic [FW-1:0] thr_frac,
  output logic          hit
);
  function automatic logic [PW-1:0] scaled_peak(input logic [MW-1:0] p,
                                                input logic [FW-1:0] f);
    logic [PW-1:0] acc;
    acc = '0;
    for (int b = 0; b < FW; b++)
      if (f[b]) acc = acc + (PW'(p) << b);
    return acc;
  endfunction

  logic [PW-1:0] err_scaled;
  logic [PW-1:0] thr_level;
  logic          peak_zero;

  assign err_scaled = {err_mag, {FW{1'b0}}};
  assign thr_level  = scaled_peak(peak, thr_frac);
  assign peak_zero  = (peak == '0);
  assign hit        = !peak_zero && (err_scaled >= thr_level);
endmodule

// File: rtl/hang_timer.sv
module hang_timer #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          hit,
  input  logic [HW-1:0] hang_len,
  output logic          freeze,
  output logic          dt_flag
);
  logic [HW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain  <= '0;
      freeze  <= 1'b0;
      dt_flag <= 1'b0;
    end else if (smp_vld) begin
      dt_flag <= hit;
      if (hit) begin
        remain <= hang_len;
        freeze <= 1'b1;
      end else begin
        freeze <= (remain != '0);
        if (remain != '0) remain <= remain - 1'b1;
      end
    end
  end

  // R6
  detect_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && hit |=> freeze && dt_flag);

  // R7
  hang_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && !hit && remain == '0 |=> !freeze);

  // R8
  reload_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && hit |=> remain == $past(hang_len));

  // R9
  idle_outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(freeze) && $stable(dt_flag) && $stable(remain));
endmodule

// File: rtl/dtalk_detect.sv
module dtalk_detect #(
  parameter int DW  = 16,
  parameter int WIN = 32,
  parameter int FW  = 8,
  parameter int HW  = 8,
  localparam int MW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic [DW-1:0] far_smp,
  input  logic [DW-1:0] err_smp,
  input  logic [FW-1:0] thr_frac,
  input  logic [HW-1:0] hang_len,
  output logic          freeze,
  output logic          dt_flag
);
  logic [MW-1:0] far_mag;
  logic [MW-1:0] err_mag;
  logic [MW-1:0] far_peak;
  logic          dt_hit;

  mag_window #(.DW(DW), .WIN(WIN)) u_window (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .far_smp(far_smp),
    .cur_mag(far_mag), .peak(far_peak)
  );

  sat_mag #(.DW(DW)) u_err_mag (.smp(err_smp), .mag(err_mag));

  dt_compare #(.MW(MW), .FW(FW)) u_compare (
    .err_mag(err_mag), .peak(far_peak), .thr_frac(thr_frac), .hit(dt_hit)
  );

  hang_timer #(.HW(HW)) u_hang (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .hit(dt_hit),
    .hang_len(hang_len), .freeze(freeze), .dt_flag(dt_flag)
  );

  // R5
  silent_far_no_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld && far_peak == '0 |=> !dt_flag);

  // R2
  most_negative_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    far_smp == {1'b1, {(DW-1){1'b0}}} |-> far_mag == {MW{1'b1}});

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !freeze && !dt_flag);
endmodule

// File: tb/dtalk_detect_bench.sv
module dtalk_detect_bench;
  localparam int DW = 16, WIN = 32, FW = 8, HW = 8;

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0;
  logic signed [DW-1:0] far_smp = '0, err_smp = '0;
  logic [FW-1:0] thr_frac = 8'd128;
  logic [HW-1:0] hang_len = 8'd3;
  logic freeze, dt_flag;

  int nvec = 0, nbad = 0;
  int bhist [WIN-1];
  int bcnt = 0;
  bit bfreeze = 0, bflag = 0;

  always #10 clk = ~clk;

  dtalk_detect #(.DW(DW), .WIN(WIN), .FW(FW), .HW(HW)) u_dtalk_detect (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .far_smp(far_smp),
    .err_smp(err_smp), .thr_frac(thr_frac), .hang_len(hang_len),
    .freeze(freeze), .dt_flag(dt_flag)
  );

  function automatic int b_mag(input int v);
    if (v < 0) v = -v;
    return (v > 32767) ? 32767 : v;
  endfunction

  function automatic bit b_detect(input int emag, input int pk, input int thr);
    longint lhs, rhs;
    lhs = longint'(emag) * 256;
    rhs = longint'(thr) * longint'(pk);
    return (pk != 0) && (lhs >= rhs);
  endfunction

  task automatic check(input string tag);
    nvec++;
    if (freeze !== bfreeze || dt_flag !== bflag) begin
      nbad++;
      $display("FAIL %s: freeze=%0b dt_flag=%0b expected freeze=%0b dt_flag=%0b",
               tag, freeze, dt_flag, bfreeze, bflag);
    end
  endtask

  task automatic step(input bit v, input int far, input int err, input string tag);
    int pk, cm;
    bit det;
    smp_vld = v;
    far_smp = DW'(far);
    err_smp = DW'(err);
    if (v) begin
      cm = b_mag(far);
      pk = cm;
      for (int i = 0; i < WIN - 1; i++) if (bhist[i] > pk) pk = bhist[i];
      det = b_detect(b_mag(err), pk, int'(thr_frac));
      bflag = det;
      if (det) begin
        bfreeze = 1; bcnt = int'(hang_len);
      end else begin
        bfreeze = (bcnt != 0);
        if (bcnt != 0) bcnt--;
      end
      for (int i = WIN - 2; i > 0; i--) bhist[i] = bhist[i-1];
      bhist[0] = cm;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(20 * 200000);
    nbad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    for (int i = 0; i < WIN - 1; i++) bhist[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R5: silent far end, loud error
    step(1, 0, 20000, "R5 zero peak");
    // R4: equality boundary at one half
    step(1, 1000, 499, "R4 below threshold");
    step(1, 1000, 500, "R4 at threshold");
    // R7: hangover of 3 then release
    for (int k = 0; k < 5; k++) step(1, 1000, 0, "R7 hangover");
    // R8: reload inside hangover
    step(1, 1000, 900, "R8 first detect");
    step(1, 1000, 0, "R8 quiet");
    step(1, 1000, 0, "R8 quiet");
    step(1, 1000, 900, "R8 reload detect");
    for (int k = 0; k < 3; k++) step(1, 1000, 0, "R8 held after reload");
    step(1, 1000, 0, "R8 release");
    // R9: idle clocks with loud data
    for (int k = 0; k < 4; k++) step(0, 30000, 30000, "R9 idle");
    // R3: window edge, idle clocks inside the run
    for (int k = 0; k < WIN; k++) step(1, 0, 0, "R3 flush");
    hang_len = 8'd0;
    step(1, 20000, 10000, "R3 loud sample");
    for (int k = 1; k < WIN; k++) begin
      if (k == 10) for (int j = 0; j < 3; j++) step(0, 0, 30000, "R9 idle in window");
      step(1, 0, 10000, "R3 inside window");
    end
    step(1, 0, 10000, "R3 aged out");
    step(1, 0, 10000, "R3 after aging");
    // R2: most negative codes
    thr_frac = 8'd255;
    step(1, -32768, -32768, "R2 both most negative");
    step(1, -32768, 32766, "R2 far most negative");
    step(1, 32767, -32768, "R2 err most negative");
    thr_frac = 8'd0;
    step(1, 5, 0, "R4 zero fraction");

    // R4 R6 R7 R8 R9: random traffic
    for (int n = 0; n < 4000; n++) begin
      int sh, far, err;
      bit v;
      if (n % 200 == 0) begin
        thr_frac = FW'($urandom_range(255));
        hang_len = HW'($urandom_range(7));
      end
      v   = ($urandom_range(9) < 7);
      sh  = $urandom_range(15);
      far = int'($urandom_range(65535)) - 32768;
      far = far >>> sh;
      err = int'($urandom_range(65535)) - 32768;
      err = err >>> $urandom_range(15);
      if ($urandom_range(49) == 0) far = -32768;
      if ($urandom_range(49) == 0) err = -32768;
      step(v, far, err, v ? "R4 R7 R8 random" : "R9 random idle");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule